// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the external bus cycles of a 16-bit core over one set of shared address/data lines that is 20 bits wide. The core presents a request through a valid/ready handshake. The request carries a memory-or-I/O flag, a read-or-write flag, the address, the write data, a 2-bit segment code and the interrupt-enable flag. The sequencer then steps through four phases, T1 to T4. In T1 it drives the address and pulses the address latch enable. From T2 it swaps the four upper lines for status bits and asserts the read or write strobe. It returns the read data in T4, together with a one-cycle response pulse.

A ready input that is low stretches the cycle. Each low sample adds one wait phase between T3 and T4. When no request is pending, the sequencer sits in idle. An external master can ask for the bus with a hold input. The request is granted only between cycles. While granted, every output-enable flag drops and the acknowledge goes high. The output-enable flags stand in for the tristate control of the pins.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the block is idle. In idle, ale_o, rd_o, wr_o, den_o, hlda_o, rsp_valid_o, ad_hi_oe_o and ad_lo_oe_o are 0, while ctl_oe_o is 1 and req_ready_o is 1 when hold_i is low.
- R2: A request accepted at a clock edge (req_valid_i and req_ready_o both high) starts T1 in the next cycle. With ready_i high the cycle lasts exactly four clocks. ale_o is 1 only in T1, and rsp_valid_o is 1 only in T4.
- R3: ready_i is sampled in T3 and in every wait phase. Each low sample inserts one wait phase before T4, so N low samples give a cycle of 4+N clocks. The strobe, the status and the write data hold through the wait phases.
- R4: In T1, bus_ad_o carries the full 20-bit address for a memory cycle. For an I/O cycle it carries the 16-bit port address in bits 15..0, with bits 19..16 at 0. Both output enables are 1 in T1.
- R5: From T2 through T4, bits 19..16 of bus_ad_o carry status. Bit 19 is 0, bit 18 is the interrupt-enable flag, and bits 17..16 are the segment code: 00 extra, 01 stack, 10 code, 11 data.
- R6: rd_o (read cycles) or wr_o (write cycles) is 1 from T2 through T3 and any wait phases. It is 0 in T1 and T4, and the two strobes are never 1 together.
- R7: During T1 to T4, dt_r_o is 1 for a write and 0 for a read, and mem_io_o is 1 for memory and 0 for I/O. den_o is 1 from T2 through T4.
- R8: In a write cycle, bits 15..0 carry the write data with ad_lo_oe_o set from T2 through T4. In a read cycle, ad_lo_oe_o is 0 in those phases. rsp_rdata_o in T4 equals the bus_ad_i value present in the last T3 or wait phase.
- R9: hold_i high at a cycle boundary (idle or T4) moves the block to the hold state in the next cycle. In hold, hlda_o is 1, ad_hi_oe_o, ad_lo_oe_o and ctl_oe_o are 0, and req_ready_o is 0, so a pending request has no effect. Dropping hold_i returns the block to idle in the next cycle.
- R10: hold_i raised inside a cycle does not cut the cycle short: hlda_o stays 0 until T4 has completed. At a boundary, hold takes precedence over a pending request.
- R11: A request valid during T4 is accepted there, and its T1 follows T4 directly with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Request accepted at this edge when valid |
| req_io_i | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | Cycle address |
| req_wdata_i | input | 16 | Write data |
| req_seg_i | input | 2 | Segment code for status |
| req_ief_i | input | 1 | Interrupt-enable flag for status |
| rsp_valid_o | output | 1 | Cycle completes (T4) |
| rsp_rdata_o | output | 16 | Read data, valid with rsp_valid_o on reads |
| ready_i | input | 1 | Low requests a wait phase |
| hold_i | input | 1 | External bus request |
| hlda_o | output | 1 | Bus granted to external master |
| bus_ad_o | output | 20 | Multiplexed address/status/data out |
| bus_ad_i | input | 16 | Data lines in |
| ad_hi_oe_o | output | 1 | Drive enable, lines 19..16 |
| ad_lo_oe_o | output | 1 | Drive enable, lines 15..0 |
| ale_o | output | 1 | Address latch enable |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| mem_io_o | output | 1 | 1 = memory, 0 = I/O |
| dt_r_o | output | 1 | 1 = transmit, 0 = receive |
| den_o | output | 1 | Data buffer enable, active high |
| ctl_oe_o | output | 1 | Drive enable for the control lines |

## Verification
The bench uses the default widths: 20 address lines, 16 data lines and a 16-bit port space. This leaves four status lines, so every segment code and interrupt-flag value shows up in the actual upper bits. It sweeps both cycle kinds, both directions, all four segments, both flag values and zero to three wait phases, checking every phase against the expected pattern. Separate runs cover hold from idle, hold raised in the middle of a cycle while another request is pending, and back-to-back requests.

// File: rtl/bus_seq_pkg.sv
`timescale 1ns/1ps
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TW,
    ST_T4,
    ST_HOLD
  } bus_state_e;

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_STACK = 2'b01,
    SEG_CODE  = 2'b10,
    SEG_DATA  = 2'b11
  } seg_e;
endpackage

// File: rtl/bus_seq_fsm.sv
`timescale 1ns/1ps
module bus_seq_fsm
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_io_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [1:0]        req_seg_i,
  input  logic              req_ief_i,
  input  logic              ready_i,
  input  logic              hold_i,
  output logic              req_ready_o,
  output bus_state_e        state_o,
  output logic              cur_io_o,
  output logic              cur_write_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [DATA_W-1:0] cur_wdata_o,
  output logic [1:0]        cur_seg_o,
  output logic              cur_ief_o
);
  bus_state_e state_q, state_d;
  logic boundary, accept;

  assign boundary    = (state_q == ST_IDLE) || (state_q == ST_T4);
  assign req_ready_o = boundary && !hold_i;
  assign accept      = req_ready_o && req_valid_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (hold_i)           state_d = ST_HOLD;
        else if (req_valid_i) state_d = ST_T1;
      end
      ST_T1:        state_d = ST_T2;
      ST_T2:        state_d = ST_T3;
      ST_T3, ST_TW: state_d = ready_i ? ST_T4 : ST_TW;
      ST_T4: begin
        if (hold_i)           state_d = ST_HOLD;
        else if (req_valid_i) state_d = ST_T1;
        else                  state_d = ST_IDLE;
      end
      ST_HOLD: if (!hold_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // request captured at acceptance, held for the whole cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_io_o    <= 1'b0;
      cur_write_o <= 1'b0;
      cur_addr_o  <= '0;
      cur_wdata_o <= '0;
      cur_seg_o   <= 2'b00;
      cur_ief_o   <= 1'b0;
    end else if (accept) begin
      cur_io_o    <= req_io_i;
      cur_write_o <= req_write_i;
      cur_addr_o  <= req_addr_i;
      cur_wdata_o <= req_wdata_i;
      cur_seg_o   <= req_seg_i;
      cur_ief_o   <= req_ief_i;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/bus_seq_drive.sv
`timescale 1ns/1ps
module bus_seq_drive
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int IO_W   = 16
) (
  input  bus_state_e        state_i,
  input  logic              cur_io_i,
  input  logic              cur_write_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [DATA_W-1:0] cur_wdata_i,
  input  logic [1:0]        cur_seg_i,
  input  logic              cur_ief_i,
  output logic [ADDR_W-1:0] bus_ad_o,
  output logic              ad_hi_oe_o,
  output logic              ad_lo_oe_o
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] IO_MASK = {{(ADDR_W-IO_W){1'b0}}, {IO_W{1'b1}}};

  logic [HI_W-1:0]   stat_w;
  logic [ADDR_W-1:0] t1_addr;
  logic              addr_ph, data_ph;

  // status layout: [1:0] segment, [2] interrupt flag, rest tied low
  for (genvar b = 0; b < HI_W; b++) begin : g_stat
    if (b < 2) begin : g_seg
      assign stat_w[b] = cur_seg_i[b];
    end else if (b == 2) begin : g_ief
      assign stat_w[b] = cur_ief_i;
    end else begin : g_zero
      assign stat_w[b] = 1'b0;
    end
  end

  assign addr_ph = (state_i == ST_T1);
  assign data_ph = (state_i == ST_T2) || (state_i == ST_T3) ||
                   (state_i == ST_TW) || (state_i == ST_T4);
  assign t1_addr = cur_io_i ? (cur_addr_i & IO_MASK) : cur_addr_i;

  always_comb begin
    if (addr_ph) begin
      bus_ad_o = t1_addr;
    end else begin
      bus_ad_o[ADDR_W-1:DATA_W] = stat_w;
      bus_ad_o[DATA_W-1:0]      = cur_write_i ? cur_wdata_i : '0;
    end
  end

  assign ad_hi_oe_o = addr_ph || data_ph;
  assign ad_lo_oe_o = addr_ph || (data_ph && cur_write_i);
endmodule

// File: rtl/bus_seq_strobe.sv
`timescale 1ns/1ps
module bus_seq_strobe
  import bus_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_state_e        state_i,
  input  logic              cur_io_i,
  input  logic              cur_write_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] bus_ad_i,
  output logic              ale_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              mem_io_o,
  output logic              dt_r_o,
  output logic              den_o,
  output logic              ctl_oe_o,
  output logic              hlda_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  logic strobe_ph, end_ph;

  assign strobe_ph = (state_i == ST_T2) || (state_i == ST_T3) || (state_i == ST_TW);
  assign end_ph    = (state_i == ST_T3) || (state_i == ST_TW);

  assign ale_o       = (state_i == ST_T1);
  assign rd_o        = strobe_ph && !cur_write_i;
  assign wr_o        = strobe_ph &&  cur_write_i;
  assign den_o       = strobe_ph || (state_i == ST_T4);
  assign mem_io_o    = !cur_io_i;
  assign dt_r_o      = cur_write_i;
  assign hlda_o      = (state_i == ST_HOLD);
  assign ctl_oe_o    = !hlda_o;
  assign rsp_valid_o = (state_i == ST_T4);

  // sample at the edge that enters T4
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               rsp_rdata_o <= '0;
    else if (end_ph && ready_i && !cur_write_i) rsp_rdata_o <= bus_ad_i;
  end
endmodule

// File: rtl/mux_bus_seq.sv
`timescale 1ns/1ps
module mux_bus_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int IO_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_io_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [1:0]        req_seg_i,
  input  logic              req_ief_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              ready_i,
  input  logic              hold_i,
  output logic              hlda_o,
  output logic [ADDR_W-1:0] bus_ad_o,
  input  logic [DATA_W-1:0] bus_ad_i,
  output logic              ad_hi_oe_o,
  output logic              ad_lo_oe_o,
  output logic              ale_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              mem_io_o,
  output logic              dt_r_o,
  output logic              den_o,
  output logic              ctl_oe_o
);
  bus_state_e        state;
  logic              cur_io, cur_write, cur_ief;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic [1:0]        cur_seg;

  bus_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_io_i    (req_io_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_seg_i   (req_seg_i),
    .req_ief_i   (req_ief_i),
    .ready_i     (ready_i),
    .hold_i      (hold_i),
    .req_ready_o (req_ready_o),
    .state_o     (state),
    .cur_io_o    (cur_io),
    .cur_write_o (cur_write),
    .cur_addr_o  (cur_addr),
    .cur_wdata_o (cur_wdata),
    .cur_seg_o   (cur_seg),
    .cur_ief_o   (cur_ief)
  );

  bus_seq_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_W(IO_W)) u_drive (
    .state_i     (state),
    .cur_io_i    (cur_io),
    .cur_write_i (cur_write),
    .cur_addr_i  (cur_addr),
    .cur_wdata_i (cur_wdata),
    .cur_seg_i   (cur_seg),
    .cur_ief_i   (cur_ief),
    .bus_ad_o    (bus_ad_o),
    .ad_hi_oe_o  (ad_hi_oe_o),
    .ad_lo_oe_o  (ad_lo_oe_o)
  );

  bus_seq_strobe #(.DATA_W(DATA_W)) u_strobe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .cur_io_i    (cur_io),
    .cur_write_i (cur_write),
    .ready_i     (ready_i),
    .bus_ad_i    (bus_ad_i),
    .ale_o       (ale_o),
    .rd_o        (rd_o),
    .wr_o        (wr_o),
    .mem_io_o    (mem_io_o),
    .dt_r_o      (dt_r_o),
    .den_o       (den_o),
    .ctl_oe_o    (ctl_oe_o),
    .hlda_o      (hlda_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );
endmodule

// File: rtl/bus_seq_chk.sv
`timescale 1ns/1ps
module bus_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              ready_i,
  input logic              rsp_valid_o,
  input logic              hlda_o,
  input logic [ADDR_W-1:0] bus_ad_o,
  input logic              ad_hi_oe_o,
  input logic              ad_lo_oe_o,
  input logic              ale_o,
  input logic              rd_o,
  input logic              wr_o,
  input logic              den_o,
  input logic              ctl_oe_o
);
  AST_ACCEPT_STARTS_T1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> ale_o); // R2

  AST_ALE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o); // R2

  AST_RSP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R2

  AST_WAIT_KEEPS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) && !ready_i |=> (rd_o || wr_o)); // R3

  AST_STATUS_TOP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_hi_oe_o && !ale_o |-> !bus_ad_o[ADDR_W-1]); // R5

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o)); // R6

  AST_NO_STROBE_IN_T1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> !rd_o && !wr_o && !den_o); // R6

  AST_HOLD_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> !ad_hi_oe_o && !ad_lo_oe_o && !ctl_oe_o && !req_ready_o); // R9

  AST_HOLD_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hlda_o) |-> $past(rsp_valid_o || !den_o)); // R10
endmodule

bind mux_bus_seq bus_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mux_bus_seq_test.sv
`timescale 1ns/1ps
module mux_bus_seq_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_io_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [19:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [1:0]  req_seg_i = '0;
  logic        req_ief_i = 1'b0;
  logic        rsp_valid_o;
  logic [15:0] rsp_rdata_o;
  logic        ready_i = 1'b1;
  logic        hold_i = 1'b0;
  logic        hlda_o;
  logic [19:0] bus_ad_o;
  logic [15:0] bus_ad_i = '0;
  logic        ad_hi_oe_o, ad_lo_oe_o, ale_o, rd_o, wr_o;
  logic        mem_io_o, dt_r_o, den_o, ctl_oe_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mux_bus_seq uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_io_i(req_io_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .req_seg_i(req_seg_i), .req_ief_i(req_ief_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .ready_i(ready_i), .hold_i(hold_i), .hlda_o(hlda_o),
    .bus_ad_o(bus_ad_o), .bus_ad_i(bus_ad_i),
    .ad_hi_oe_o(ad_hi_oe_o), .ad_lo_oe_o(ad_lo_oe_o),
    .ale_o(ale_o), .rd_o(rd_o), .wr_o(wr_o),
    .mem_io_o(mem_io_o), .dt_r_o(dt_r_o), .den_o(den_o),
    .ctl_oe_o(ctl_oe_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, "ale", ale_o, 0);
    chk(tag, "rd", rd_o, 0);
    chk(tag, "wr", wr_o, 0);
    chk(tag, "den", den_o, 0);
    chk(tag, "hlda", hlda_o, 0);
    chk(tag, "rsp_valid", rsp_valid_o, 0);
    chk(tag, "hi_oe", ad_hi_oe_o, 0);
    chk(tag, "lo_oe", ad_lo_oe_o, 0);
    chk(tag, "ctl_oe", ctl_oe_o, 1);
  endtask

  task automatic chk_hold(input string tag);
    chk(tag, "hlda", hlda_o, 1);
    chk(tag, "hi_oe", ad_hi_oe_o, 0);
    chk(tag, "lo_oe", ad_lo_oe_o, 0);
    chk(tag, "ctl_oe", ctl_oe_o, 0);
    chk(tag, "req_ready", req_ready_o, 0);
    chk(tag, "ale", ale_o, 0);
  endtask

  task automatic chk_t1(input logic io, input logic wr, input logic [19:0] a);
    logic [19:0] exp_a;
    exp_a = io ? {4'h0, a[15:0]} : a;
    chk("R2", "ale in T1", ale_o, 1);
    chk("R4", "T1 address", bus_ad_o, exp_a);
    chk("R4", "T1 hi_oe", ad_hi_oe_o, 1);
    chk("R4", "T1 lo_oe", ad_lo_oe_o, 1);
    chk("R6", "T1 strobes", {rd_o, wr_o}, 0);
    chk("R7", "T1 dt_r", dt_r_o, wr);
    chk("R7", "T1 mem_io", mem_io_o, !io);
    chk("R7", "T1 den", den_o, 0);
  endtask

  // T2, T3 and wait phases
  task automatic chk_mid(input string ph, input logic io, input logic wr,
                         input logic [1:0] seg, input logic ief, input logic [15:0] wd);
    chk("R2", {ph, " ale"}, ale_o, 0);
    chk("R2", {ph, " rsp_valid"}, rsp_valid_o, 0);
    chk("R5", {ph, " status"}, bus_ad_o[19:16], {1'b0, ief, seg});
    chk("R6", {ph, " rd"}, rd_o, !wr);
    chk("R6", {ph, " wr"}, wr_o, wr);
    chk("R7", {ph, " den"}, den_o, 1);
    chk("R7", {ph, " dt_r"}, dt_r_o, wr);
    chk("R7", {ph, " mem_io"}, mem_io_o, !io);
    chk("R8", {ph, " lo_oe"}, ad_lo_oe_o, wr);
    if (wr) chk("R8", {ph, " wdata"}, bus_ad_o[15:0], wd);
    chk("R10", {ph, " hlda"}, hlda_o, 0);
  endtask

  // mode 0: plain, 1: hold raised in T2 with pending request at T4, 2: back-to-back
  task automatic run_cycle(input logic io, input logic wr, input logic [1:0] seg,
                           input logic ief, input logic [19:0] a, input logic [15:0] wd,
                           input logic [15:0] rdv, input int nw, input int mode);
    req_io_i = io; req_write_i = wr; req_seg_i = seg; req_ief_i = ief;
    req_addr_i = a; req_wdata_i = wd; req_valid_i = 1'b1;
    chk("R1", "req_ready before accept", req_ready_o, 1);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk_t1(io, wr, a);
    @(negedge clk);
    if (mode == 1) hold_i = 1'b1;
    chk_mid("T2", io, wr, seg, ief, wd);
    @(negedge clk);
    chk_mid("T3", io, wr, seg, ief, wd);
    ready_i  = (nw == 0);
    bus_ad_i = (nw == 0) ? rdv : ~rdv;
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      chk_mid("TW", io, wr, seg, ief, wd);
      chk("R3", "wait hi_oe", ad_hi_oe_o, 1);
      ready_i  = (w == nw - 1);
      bus_ad_i = (w == nw - 1) ? rdv : ~rdv;
    end
    @(negedge clk);
    ready_i = 1'b1;
    bus_ad_i = 16'h0;
    chk("R2", "T4 rsp_valid", rsp_valid_o, 1);
    chk("R3", "T4 after waits strobes", {rd_o, wr_o}, 0);
    chk("R6", "T4 strobes", {rd_o, wr_o}, 0);
    chk("R7", "T4 den", den_o, 1);
    chk("R5", "T4 status", bus_ad_o[19:16], {1'b0, ief, seg});
    chk("R8", "T4 lo_oe", ad_lo_oe_o, wr);
    if (!wr) chk("R8", "read data", rsp_rdata_o, rdv);
    chk("R10", "T4 hlda", hlda_o, 0);
    if (mode != 0) req_valid_i = 1'b1;
    @(negedge clk);
    if (mode == 0) chk_idle("R2");
    else if (mode == 1) chk_hold("R10");
    else begin
      req_valid_i = 1'b0;
      chk_t1(io, wr, a);
      chk("R11", "back-to-back T1", ale_o, 1);
    end
  endtask

  task automatic drain();
    int guard = 0;
    while (!rsp_valid_o && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_idle("R1");
    chk("R1", "req_ready", req_ready_o, 1);

    // full sweep
    for (int i = 0; i < 128; i++) begin
      logic        io, wr, ief;
      logic [1:0]  seg;
      int          nw;
      logic [19:0] a;
      logic [15:0] wd, rdv;
      io  = i[0];
      wr  = i[1];
      seg = i[3:2];
      ief = i[4];
      nw  = i[6:5];
      a   = 20'h5A5A5 ^ (20'(i) * 20'h1F3D7);
      wd  = 16'hC3A5 + 16'(i * 16'h0101);
      rdv = 16'h9E37 ^ 16'(i * 16'h1111);
      run_cycle(io, wr, seg, ief, a, wd, rdv, nw, 0);
    end

    // hold from idle, request ignored while granted
    hold_i = 1'b1;
    req_io_i = 1'b0; req_write_i = 1'b0; req_addr_i = 20'hABCDE;
    req_seg_i = 2'b10; req_ief_i = 1'b1; req_valid_i = 1'b1;
    @(negedge clk);
    chk_hold("R9");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk_hold("R9");
      chk("R9", "no strobe in hold", {rd_o, wr_o, den_o}, 0);
    end
    hold_i = 1'b0;
    @(negedge clk);
    chk("R9", "hlda released", hlda_o, 0);
    chk("R9", "idle after hold ale", ale_o, 0);
    chk("R9", "ready after hold", req_ready_o, 1);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R9", "pending req starts", ale_o, 1);
    chk("R4", "pending req address", bus_ad_o, 20'hABCDE);
    drain();

    // hold during a cycle with a request waiting at T4
    run_cycle(1'b0, 1'b0, 2'b01, 1'b0, 20'h12345, 16'h0, 16'hBEEF, 1, 1);
    @(negedge clk);
    chk_hold("R10");
    hold_i = 1'b0;
    @(negedge clk);
    chk("R10", "hlda drop", hlda_o, 0);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R10", "deferred req T1", ale_o, 1);
    chk("R4", "deferred req address", bus_ad_o, 20'h12345);
    drain();

    // back-to-back
    run_cycle(1'b1, 1'b1, 2'b11, 1'b1, 20'hF0F0F, 16'h5AA5, 16'h0, 2, 2);
    drain();
    chk_idle("R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule